// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one IEEE 754 binary value and returns an integral value in the same binary format. The value is rounded to the nearest integer, and an exact halfway case goes to the integer of larger magnitude. No integer-format conversion is done: a double in gives a double out, a single gives a single, a half gives a half. Zeros and infinities keep their value and sign. NaNs follow the ordinary arithmetic propagation rules. The operation is non-exact, so it never reports an inexact condition.

A 2-bit selector picks the format: 1 is half, 2 is single and 3 is double. Code 0 is rejected and raises an undefined-format flag. The operand arrives on a 64-bit bus, with narrower formats taken from the low bits. The result leaves on a 64-bit bus with every bit above the active format cleared. Half-precision results therefore sit zero-extended inside a 32-bit lane. Each request is qualified by a valid strobe, and the registered result appears one clock later.

Top module: `fp_round_integral`

## Requirements
- R1: A value exactly halfway between two integers rounds away from zero (2.5 gives 3.0, -2.5 gives -3.0, 0.5 gives 1.0, -0.5 gives -1.0).
- R2: A value that is not a tie rounds to the nearest integer, and a carry out of the fraction correctly increments the exponent (3.5 gives 4.0, 8388607.5 in single gives 8388608.0).
- R3: A zero keeps its value and sign, and any finite magnitude below 0.5, subnormals included, returns a zero carrying the input's sign bit.
- R4: An infinity (exponent all ones, fraction zero) is returned unchanged.
- R5: A quiet NaN (exponent all ones, fraction MSB set) is returned unchanged and does not raise out_invalid.
- R6: A signalling NaN (exponent all ones, fraction MSB clear, fraction non-zero) is returned with its fraction MSB set, and out_invalid is raised.
- R7: A finite input whose unbiased exponent is at least the fraction width (10, 23 or 52) is returned unchanged.
- R8: Selector value 0 raises out_undef, forces out_result to zero and keeps out_invalid low, whatever the operand holds.
- R9: Selector 1 (half) reads in_op[15:0] and drives out_result[63:16] to zero. Selector 2 (single) reads in_op[31:0] and drives out_result[63:32] to zero. Selector 3 (double) uses all 64 bits.
- R10: When in_valid is high at a rising edge, out_valid is high for the following cycle and carries that request's result. When in_valid is low, out_valid, out_invalid and out_undef are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Format selector: 1 half, 2 single, 3 double, 0 undefined |
| in_op | input | 64 | Operand, low-aligned for narrow formats |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Rounded value, zero above the active format |
| out_invalid | output | 1 | Signalling NaN seen on a defined format |
| out_undef | output | 1 | Selector code 0 was requested |

## Verification
A format rejection and NaN detection can both fire on the same request. To provoke this, the bench sends selector code 0 together with an operand that holds a signalling-NaN pattern in its low bits. The bench checks that out_undef is high, that out_invalid stays low and that the result is forced to zero, so the rejection takes precedence. The bench also places a tie-rounding carry into the exponent next to requests of another format, and checks that each result is cleared above its own width.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

    localparam int OP_W = 64;

    localparam int H_EW = 5;
    localparam int H_FW = 10;
    localparam int S_EW = 8;
    localparam int S_FW = 23;
    localparam int D_EW = 11;
    localparam int D_FW = 52;

    localparam int H_W = H_EW + H_FW + 1;
    localparam int S_W = S_EW + S_FW + 1;
    localparam int D_W = D_EW + D_FW + 1;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_HALF   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [OP_W-1:0] result;
        logic            invalid;
        logic            undef;
    } rnd_out_t;

    function automatic logic fmt_defined(input fmt_e f);
        return f != FMT_NONE;
    endfunction

endpackage

// File: rtl/fpri_lane.sv
module fpri_lane #(
    parameter int EW = 11,
    parameter int FW = 52
) (
    input  logic [EW+FW:0] x,
    output logic [EW+FW:0] y,
    output logic           snan
);
    localparam int MW = EW + FW;
    localparam logic [EW-1:0] EXP_ONES = {EW{1'b1}};
    localparam int BIAS = (1 << (EW - 1)) - 1;

    logic          sgn;
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;
    logic [MW-1:0] mag;
    logic [MW-1:0] mask;
    logic [MW-1:0] half;
    logic [MW-1:0] sum;
    int            ex_i;
    int            nfrac;

    assign sgn = x[MW];
    assign ex  = x[MW-1:FW];
    assign fr  = x[FW-1:0];
    assign mag = x[MW-1:0];

    always_comb begin
        ex_i  = int'(ex);
        nfrac = BIAS + FW - ex_i;
        mask  = '0;
        half  = '0;
        sum   = '0;
        snan  = 1'b0;
        y     = x;
        if (ex == EXP_ONES) begin
            if (fr != '0) begin
                snan = ~fr[FW-1];
                y    = x;
                y[FW-1] = 1'b1;
            end
        end else if (ex_i >= BIAS + FW) begin
            y = x;
        end else if (ex_i < BIAS - 1) begin
            y = {sgn, {MW{1'b0}}};
        end else if (ex_i == BIAS - 1) begin
            y = {sgn, EW'(BIAS), {FW{1'b0}}};
        end else begin
            mask = (MW'(1) << nfrac) - MW'(1);
            half = MW'(1) << (nfrac - 1);
            sum  = mag + half;
            y    = {sgn, sum & ~mask};
        end
    end
endmodule

// File: rtl/fpri_select.sv
module fpri_select
    import fpri_pkg::*;
(
    input  fmt_e            fmt,
    input  logic [OP_W-1:0] op,
    output rnd_out_t        res
);
    logic [H_W-1:0] h_y;
    logic [S_W-1:0] s_y;
    logic [D_W-1:0] d_y;
    logic           h_sn;
    logic           s_sn;
    logic           d_sn;

    fpri_lane #(.EW(H_EW), .FW(H_FW)) u_half (
        .x(op[H_W-1:0]), .y(h_y), .snan(h_sn)
    );
    fpri_lane #(.EW(S_EW), .FW(S_FW)) u_single (
        .x(op[S_W-1:0]), .y(s_y), .snan(s_sn)
    );
    fpri_lane #(.EW(D_EW), .FW(D_FW)) u_double (
        .x(op[D_W-1:0]), .y(d_y), .snan(d_sn)
    );

    always_comb begin
        res = '0;
        res.undef = ~fmt_defined(fmt);
        unique case (fmt)
            FMT_HALF: begin
                res.result = {{(OP_W-H_W){1'b0}}, h_y};
                res.invalid = h_sn;
            end
            FMT_SINGLE: begin
                res.result = {{(OP_W-S_W){1'b0}}, s_y};
                res.invalid = s_sn;
            end
            FMT_DOUBLE: begin
                res.result = d_y;
                res.invalid = d_sn;
            end
            default: begin
                res.result = '0;
                res.invalid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
    import fpri_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      in_fmt,
    input  logic [OP_W-1:0] in_op,
    output logic            out_valid,
    output logic [OP_W-1:0] out_result,
    output logic            out_invalid,
    output logic            out_undef
);
    rnd_out_t comb_res;
    rnd_out_t res_q;
    logic     vld_q;

    fpri_select u_sel (
        .fmt(fmt_e'(in_fmt)),
        .op (in_op),
        .res(comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q.invalid <= in_valid & comb_res.invalid;
            res_q.undef   <= in_valid & comb_res.undef;
            if (in_valid) begin
                res_q.result <= comb_res.result;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_result  = res_q.result;
    assign out_invalid = res_q.invalid;
    assign out_undef   = res_q.undef;
endmodule

module fp_round_integral_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  in_fmt,
    input logic [63:0] in_op,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_invalid,
    input logic        out_undef
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_invalid && !out_undef));
    a_r8_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd0) |=> (out_undef && !out_invalid && out_result == 64'd0));
    a_r9_half_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd1) |=> (out_result[63:16] == 48'd0 && !out_undef));
    a_r9_single_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd2) |=> (out_result[63:32] == 32'd0 && !out_undef));
    a_r4_double_inf: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd3 && in_op[62:52] == 11'h7FF && in_op[51:0] == 52'd0)
        |=> (out_result == $past(in_op)));
    a_r5_double_qnan: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd3 && in_op[62:52] == 11'h7FF && in_op[51])
        |=> (out_result == $past(in_op) && !out_invalid));
endmodule

bind fp_round_integral fp_round_integral_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_undef(out_undef)
);

// File: tb/fp_round_integral_tb.sv
module fp_round_integral_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic [63:0] in_op = 64'd0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_undef;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    fp_round_integral u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_op(in_op),
        .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_undef(out_undef)
    );

    task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] f, input logic [63:0] op,
                          input logic [63:0] exp, input logic inv, input logic und);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = f;
        in_op    = op;
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq({req, " valid"}, {63'd0, out_valid}, 64'd1);
        expect_eq({req, " result"}, out_result, exp);
        expect_eq({req, " invalid"}, {63'd0, out_invalid}, {63'd0, inv});
        expect_eq({req, " undef"}, {63'd0, out_undef}, {63'd0, und});
    endtask

    task automatic t_reset;
        expect_eq("R10 reset valid", {63'd0, out_valid}, 64'd0);
        expect_eq("R10 reset result", out_result, 64'd0);
    endtask

    task automatic t_ties;
        run_op("R1 d 2.5", 2'd3, $realtobits(2.5), $realtobits(3.0), 1'b0, 1'b0);
        run_op("R1 d -2.5", 2'd3, $realtobits(-2.5), $realtobits(-3.0), 1'b0, 1'b0);
        run_op("R1 d 0.5", 2'd3, $realtobits(0.5), $realtobits(1.0), 1'b0, 1'b0);
        run_op("R1 s 2.5", 2'd2, 64'h40200000, 64'h40400000, 1'b0, 1'b0);
        run_op("R1 s -2.5", 2'd2, 64'hC0200000, 64'hC0400000, 1'b0, 1'b0);
        run_op("R1 h 2.5", 2'd1, 64'h4100, 64'h4200, 1'b0, 1'b0);
        run_op("R1 h -0.5", 2'd1, 64'hB800, 64'hBC00, 1'b0, 1'b0);
    endtask

    task automatic t_nearest;
        run_op("R2 d 2.4", 2'd3, $realtobits(2.4), $realtobits(2.0), 1'b0, 1'b0);
        run_op("R2 d 2.6", 2'd3, $realtobits(2.6), $realtobits(3.0), 1'b0, 1'b0);
        run_op("R2 d -7.3", 2'd3, $realtobits(-7.3), $realtobits(-7.0), 1'b0, 1'b0);
        run_op("R2 s 3.5 carry", 2'd2, 64'h40600000, 64'h40800000, 1'b0, 1'b0);
        run_op("R2 s 8388607.5", 2'd2, 64'h4AFFFFFF, 64'h4B000000, 1'b0, 1'b0);
        run_op("R2 h 1023.5", 2'd1, 64'h63FF, 64'h6400, 1'b0, 1'b0);
    endtask

    task automatic t_zero_small;
        run_op("R3 d -0", 2'd3, 64'h8000000000000000, 64'h8000000000000000, 1'b0, 1'b0);
        run_op("R3 d +0", 2'd3, 64'h0, 64'h0, 1'b0, 1'b0);
        run_op("R3 d subnormal", 2'd3, 64'h1, 64'h0, 1'b0, 1'b0);
        run_op("R3 d -0.49", 2'd3, $realtobits(-0.49), 64'h8000000000000000, 1'b0, 1'b0);
        run_op("R3 s -0.3", 2'd2, 64'hBE99999A, 64'h80000000, 1'b0, 1'b0);
    endtask

    task automatic t_special;
        run_op("R4 d -inf", 2'd3, 64'hFFF0000000000000, 64'hFFF0000000000000, 1'b0, 1'b0);
        run_op("R4 s +inf", 2'd2, 64'h7F800000, 64'h7F800000, 1'b0, 1'b0);
        run_op("R5 d qnan", 2'd3, 64'hFFF8000000000123, 64'hFFF8000000000123, 1'b0, 1'b0);
        run_op("R5 h qnan", 2'd1, 64'h7E00, 64'h7E00, 1'b0, 1'b0);
        run_op("R6 d snan", 2'd3, 64'h7FF0000000000001, 64'h7FF8000000000001, 1'b1, 1'b0);
        run_op("R6 s snan", 2'd2, 64'h7F800001, 64'h7FC00001, 1'b1, 1'b0);
        run_op("R6 h snan", 2'd1, 64'h7C01, 64'h7E01, 1'b1, 1'b0);
    endtask

    task automatic t_large;
        run_op("R7 d 2^52+1", 2'd3, 64'h4330000000000001, 64'h4330000000000001, 1'b0, 1'b0);
        run_op("R7 s 8388609", 2'd2, 64'h4B000001, 64'h4B000001, 1'b0, 1'b0);
        run_op("R7 h 1025", 2'd1, 64'h6401, 64'h6401, 1'b0, 1'b0);
    endtask

    task automatic t_undef;
        run_op("R8 undef with snan bits", 2'd0, 64'h7FF0000000000001, 64'h0, 1'b0, 1'b1);
        run_op("R8 undef with half snan", 2'd0, 64'h7C01, 64'h0, 1'b0, 1'b1);
    endtask

    task automatic t_lanes;
        run_op("R9 half upper garbage", 2'd1, 64'hDEADBEEF12344100, 64'h4200, 1'b0, 1'b0);
        run_op("R9 single upper garbage", 2'd2, 64'hCAFEF00D40200000, 64'h40400000, 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        in_fmt   = 2'd0;
        in_op    = 64'h7FF0000000000001;
        @(negedge clk);
        expect_eq("R10 idle valid", {63'd0, out_valid}, 64'd0);
        expect_eq("R10 idle undef", {63'd0, out_undef}, 64'd0);
        expect_eq("R10 idle invalid", {63'd0, out_invalid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ties();
        t_nearest();
        t_zero_small();
        t_special();
        t_large();
        t_undef();
        t_lanes();
        t_idle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule